// File: doc/BRIEF.md
# Low-Power Lane Sequence Decoder

This block watches the pair of single-ended low-power line bits of a serial data lane. It brings them into the clock domain through a synchroniser and follows the control sequences that begin at the Stop state. There are three requests it recognises: handing the lane over to high-speed reception, entering escape mode, and reversing the lane direction (bus turnaround). Inside escape mode it decodes spaced-one-hot symbols into bits. The first eight bits form an entry command, which selects low-power data bytes, the ultra-low-power state or a trigger. The block reports the current mode on level flags and gives one-cycle pulses for events. Decoded data bytes leave on a byte bus with a valid strobe, and any illegal line sequence is flagged.

The decoder acts on changes of the synchronised line state, so a line state may last any number of clocks. The state machine has fourteen states.
- `ST_WAIT_STOP` is entered after reset and after any error. It ignores everything until the lines read Stop, then goes to `ST_STOP`.
- From `ST_STOP`, Mark-0 leads to `ST_HS_RQ`, and a Space after it leads to `ST_HS`. `ST_HS` returns to `ST_STOP` on Stop.
- From `ST_STOP`, Mark-1 leads to `ST_ENT_A`, and Space leads on to `ST_ENT_B`. From `ST_ENT_B`, Mark-0 goes to `ST_ESC_RQ` and Mark-1 goes to `ST_BTA_RQ`.
- In `ST_ESC_RQ`, a Space enters `ST_ESC_CMD`. In `ST_BTA_RQ`, a Space pulses turnaround and goes to `ST_WAIT_STOP`.
- `ST_ESC_CMD` branches on the command byte to `ST_ESC_LPDT`, `ST_ESC_TRIG`, `ST_ESC_BAD` or `ST_ULPS`. All four escape states go to `ST_STOP` on a legal exit and to `ST_WAIT_STOP` on a symbol error.
- In `ST_ULPS`, Mark-1 moves to `ST_ULPS_WAKE`. That state returns to `ST_STOP` when Stop follows a long enough Mark-1, and otherwise falls back to `ST_ULPS`.

Top module: `lp_lane_seq_decoder`

## Requirements
- R1: The line state is the pair {lp_p, lp_n}. Space is 00, Mark-0 is 01, Mark-1 is 10 and Stop is 11. After reset every output is low and the decoder acts only after it has seen Stop.
- R2: From Stop, the sequence Mark-0 then Space raises hs_req. hs_req stays high, whatever the lines do, until they return to Stop.
- R3: From Stop, the sequence Mark-1, Space, Mark-0, Space raises esc_mode.
- R4: From Stop, the sequence Mark-1, Space, Mark-1, Space gives a one-cycle bta_pulse with no mode flag raised. The decoder then waits for Stop.
- R5: In escape mode, Mark-0 carries a 0 bit and Mark-1 carries a 1 bit. A bit counts only when the Space after its Mark is seen. Bits are assembled least significant first.
- R6: The first eight escape bits are the entry command. When the command equals CMD_LPDT, each later group of eight bits appears on rx_byte with rx_valid high for one cycle. A byte that completes in the same cycle as the next Mark loses no bit.
- R7: A command equal to CMD_TRIG gives one trig_pulse, and later bits give no rx_valid.
- R8: Any other command raises cmd_err and blocks rx_valid until escape exit, where cmd_err drops.
- R9: A Mark-1 followed directly by Stop ends escape mode with a one-cycle esc_exit_pulse. Any partly received byte is discarded.
- R10: A command equal to CMD_ULPS raises ulps_mode and drops esc_mode.
- R11: ulps_mode is left, with a one-cycle ulps_exit_pulse, only when a Mark-1 lasting at least CLK_KHZ*WAKE_US/1000 clock cycles is followed by Stop. A shorter Mark-1 leaves ulps_mode high.
- R12: These events each give a one-cycle seq_err and drop every mode flag: a deviation from a request sequence, two Marks without a Space between them, or Stop in escape mode not directly after Mark-1. Afterwards nothing is decoded until the lines read Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_p | input | 1 | Positive low-power line bit, asynchronous |
| lp_n | input | 1 | Negative low-power line bit, asynchronous |
| hs_req | output | 1 | Lane handed to high-speed reception |
| esc_mode | output | 1 | Escape mode active |
| ulps_mode | output | 1 | Ultra-low-power state active |
| cmd_err | output | 1 | Unrecognised entry command in this escape |
| rx_byte | output | 8 | Decoded low-power data byte |
| rx_valid | output | 1 | rx_byte valid, one cycle |
| trig_pulse | output | 1 | Trigger command received |
| bta_pulse | output | 1 | Turnaround request completed |
| esc_exit_pulse | output | 1 | Escape mode left |
| ulps_exit_pulse | output | 1 | Ultra-low-power state left |
| seq_err | output | 1 | Illegal line sequence |

## Verification
Two things can happen in the same clock. The eighth bit of a byte (or of the entry command) is reported one cycle after its Space, and the Mark that starts the next bit can arrive in that same cycle. The bench provokes this by holding each line state for a single clock during a whole data escape. The scoreboard then judges it by requiring every byte to arrive intact and in order, so a lost or misplaced bit would corrupt the following byte. The same concurrency is used for the command byte: the change to data mode must coincide with the first data Mark.

// File: rtl/lpdec_pkg.sv
package lpdec_pkg;

    localparam logic [1:0] LS_SPACE = 2'b00;
    localparam logic [1:0] LS_MARK0 = 2'b01;
    localparam logic [1:0] LS_MARK1 = 2'b10;
    localparam logic [1:0] LS_STOP  = 2'b11;

    typedef enum logic [3:0] {
        ST_WAIT_STOP,
        ST_STOP,
        ST_HS_RQ,
        ST_HS,
        ST_ENT_A,
        ST_ENT_B,
        ST_ESC_RQ,
        ST_BTA_RQ,
        ST_ESC_CMD,
        ST_ESC_LPDT,
        ST_ESC_TRIG,
        ST_ESC_BAD,
        ST_ULPS,
        ST_ULPS_WAKE
    } dec_state_e;

endpackage

// File: rtl/lpdec_sync.sv
module lpdec_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] raw,
    output logic [1:0] cur,
    output logic       evt
);
    logic [1:0] stg [STAGES];
    logic [1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= 2'b00;
        else        stg[0] <= raw;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= 2'b00;
            else        stg[g] <= stg[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= stg[STAGES-1];
    end

    assign cur = stg[STAGES-1];
    assign evt = (stg[STAGES-1] != prev_q);

endmodule

// File: rtl/lpdec_wake_timer.sv
module lpdec_wake_timer #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!en)        cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == LAST);

    // R11: the wake window only completes after the timer ran in the previous cycle
    p_done_after_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(en));

endmodule

// File: rtl/lpdec_byte_asm.sv
module lpdec_byte_asm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_vld,
    input  logic         bit_val,
    output logic [W-1:0] byte_q,
    output logic         done
);
    localparam int NW = $clog2(W);
    localparam logic [NW-1:0] TOP = NW'(W - 1);

    logic [NW-1:0] idx_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
        end else if (clr) begin
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= bit_vld && (idx_q == TOP);
            if (bit_vld) begin
                byte_q <= {bit_val, byte_q[W-1:1]};
                idx_q  <= (idx_q == TOP) ? '0 : idx_q + 1'b1;
            end
        end
    end

    assign done = done_q;

    // R5: a whole byte needs several symbols, so completion never repeats back to back
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/lp_lane_seq_decoder.sv
module lp_lane_seq_decoder
    import lpdec_pkg::*;
#(
    parameter int          CLK_KHZ  = 100000,
    parameter int          WAKE_US  = 1000,
    parameter logic [7:0]  CMD_LPDT = 8'h87,
    parameter logic [7:0]  CMD_ULPS = 8'h78,
    parameter logic [7:0]  CMD_TRIG = 8'h46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_p,
    input  logic       lp_n,
    output logic       hs_req,
    output logic       esc_mode,
    output logic       ulps_mode,
    output logic       cmd_err,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       trig_pulse,
    output logic       bta_pulse,
    output logic       esc_exit_pulse,
    output logic       ulps_exit_pulse,
    output logic       seq_err
);
    localparam int WAKE_CYC = (CLK_KHZ * WAKE_US) / 1000;

    dec_state_e state_q, state_d;
    logic [1:0] cur;
    logic       evt;
    logic       pend_q, pend_d, pval_q, pval_d;
    logic       in_esc;
    logic       sym_bit, sym_err, sym_exit, ent_err;
    logic       wake_done;
    logic [7:0] asm_byte;
    logic       asm_done;

    lpdec_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({lp_p, lp_n}), .cur(cur), .evt(evt)
    );

    lpdec_wake_timer #(.CYCLES(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .en(state_q == ST_ULPS_WAKE), .done(wake_done)
    );

    lpdec_byte_asm #(.W(8)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(!in_esc),
        .bit_vld(sym_bit), .bit_val(pval_q),
        .byte_q(asm_byte), .done(asm_done)
    );

    assign in_esc = (state_q == ST_ESC_CMD) || (state_q == ST_ESC_LPDT) ||
                    (state_q == ST_ESC_TRIG) || (state_q == ST_ESC_BAD);

    // spaced-one-hot symbol tracking
    always_comb begin
        pend_d   = pend_q;
        pval_d   = pval_q;
        sym_bit  = 1'b0;
        sym_err  = 1'b0;
        sym_exit = 1'b0;
        if (!in_esc) begin
            pend_d = 1'b0;
        end else if (evt) begin
            case (cur)
                LS_SPACE: begin
                    if (pend_q) begin
                        sym_bit = 1'b1;
                        pend_d  = 1'b0;
                    end
                end
                LS_MARK0, LS_MARK1: begin
                    if (pend_q) begin
                        sym_err = 1'b1;
                        pend_d  = 1'b0;
                    end else begin
                        pend_d = 1'b1;
                        pval_d = (cur == LS_MARK1);
                    end
                end
                default: begin
                    if (pend_q && pval_q) sym_exit = 1'b1;
                    else                  sym_err  = 1'b1;
                    pend_d = 1'b0;
                end
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ent_err = 1'b0;
        unique case (state_q)
            ST_WAIT_STOP: if (cur == LS_STOP) state_d = ST_STOP;
            ST_STOP: if (evt) begin
                if (cur == LS_MARK1)      state_d = ST_ENT_A;
                else if (cur == LS_MARK0) state_d = ST_HS_RQ;
                else                      ent_err = 1'b1;
            end
            ST_HS_RQ: if (evt) begin
                if (cur == LS_SPACE) state_d = ST_HS;
                else                 ent_err = 1'b1;
            end
            ST_HS: if (evt && cur == LS_STOP) state_d = ST_STOP;
            ST_ENT_A: if (evt) begin
                if (cur == LS_SPACE) state_d = ST_ENT_B;
                else                 ent_err = 1'b1;
            end
            ST_ENT_B: if (evt) begin
                if (cur == LS_MARK0)      state_d = ST_ESC_RQ;
                else if (cur == LS_MARK1) state_d = ST_BTA_RQ;
                else                      ent_err = 1'b1;
            end
            ST_ESC_RQ: if (evt) begin
                if (cur == LS_SPACE) state_d = ST_ESC_CMD;
                else                 ent_err = 1'b1;
            end
            ST_BTA_RQ: if (evt) begin
                if (cur == LS_SPACE) state_d = ST_WAIT_STOP;
                else                 ent_err = 1'b1;
            end
            ST_ESC_CMD: begin
                if (sym_err)       state_d = ST_WAIT_STOP;
                else if (sym_exit) state_d = ST_STOP;
                else if (asm_done) begin
                    if (asm_byte == CMD_LPDT)      state_d = ST_ESC_LPDT;
                    else if (asm_byte == CMD_ULPS) state_d = ST_ULPS;
                    else if (asm_byte == CMD_TRIG) state_d = ST_ESC_TRIG;
                    else                           state_d = ST_ESC_BAD;
                end
            end
            ST_ESC_LPDT, ST_ESC_TRIG, ST_ESC_BAD: begin
                if (sym_err)       state_d = ST_WAIT_STOP;
                else if (sym_exit) state_d = ST_STOP;
            end
            ST_ULPS: if (evt && cur == LS_MARK1) state_d = ST_ULPS_WAKE;
            ST_ULPS_WAKE: if (evt) begin
                if (cur == LS_STOP && wake_done) state_d = ST_STOP;
                else                             state_d = ST_ULPS;
            end
            default: state_d = ST_WAIT_STOP;
        endcase
        if (ent_err) state_d = ST_WAIT_STOP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_STOP;
            pend_q  <= 1'b0;
            pval_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            pval_q  <= pval_d;
        end
    end

    // outputs
    always_comb begin
        hs_req          = (state_q == ST_HS);
        esc_mode        = in_esc;
        ulps_mode       = (state_q == ST_ULPS) || (state_q == ST_ULPS_WAKE);
        cmd_err         = (state_q == ST_ESC_BAD);
        rx_byte         = asm_byte;
        rx_valid        = (state_q == ST_ESC_LPDT) && asm_done;
        trig_pulse      = (state_q == ST_ESC_CMD) && asm_done && !sym_err &&
                          (asm_byte == CMD_TRIG);
        bta_pulse       = (state_q == ST_BTA_RQ) && evt && (cur == LS_SPACE);
        esc_exit_pulse  = in_esc && sym_exit;
        ulps_exit_pulse = (state_q == ST_ULPS_WAKE) && evt && (cur == LS_STOP) && wake_done;
        seq_err         = ent_err || sym_err;
    end

    // R2 R3 R10: at most one mode flag at a time
    p_modes_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_req, esc_mode, ulps_mode}));

    // R8: bytes only leave in an accepted data escape
    p_byte_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (esc_mode && !cmd_err));

    // R9: escape exit leaves escape mode
    p_exit_drops_esc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        esc_exit_pulse |=> !esc_mode && !cmd_err);

    // R11: wake exit leaves the low-power state
    p_wake_drops_ulps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ulps_exit_pulse |=> !ulps_mode);

    // R12: an error drops every mode
    p_err_drops_modes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !(hs_req || esc_mode || ulps_mode));

    // R4: turnaround raises no mode
    p_bta_no_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bta_pulse |=> !(hs_req || esc_mode || ulps_mode));

endmodule

// File: tb/tb_lp_lane_seq_decoder.sv
module tb_lp_lane_seq_decoder;

    localparam int         CLK_PERIOD = 10;
    localparam int         WAKE       = 40;
    localparam logic [7:0] C_LPDT     = 8'h87;
    localparam logic [7:0] C_ULPS     = 8'h78;
    localparam logic [7:0] C_TRIG     = 8'h46;
    localparam int         H          = 4;

    localparam int K_BYTE = 0, K_TRIG = 1, K_BTA = 2, K_EXIT = 3, K_WAKE = 4, K_SERR = 5;

    typedef struct {
        int         kind;
        logic [7:0] data;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_p = 1'b1, lp_n = 1'b1;
    logic hs_req, esc_mode, ulps_mode, cmd_err, rx_valid;
    logic trig_pulse, bta_pulse, esc_exit_pulse, ulps_exit_pulse, seq_err;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_lane_seq_decoder #(
        .CLK_KHZ(1000), .WAKE_US(WAKE),
        .CMD_LPDT(C_LPDT), .CMD_ULPS(C_ULPS), .CMD_TRIG(C_TRIG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .lp_p(lp_p), .lp_n(lp_n),
        .hs_req(hs_req), .esc_mode(esc_mode), .ulps_mode(ulps_mode),
        .cmd_err(cmd_err), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .trig_pulse(trig_pulse), .bta_pulse(bta_pulse),
        .esc_exit_pulse(esc_exit_pulse), .ulps_exit_pulse(ulps_exit_pulse),
        .seq_err(seq_err)
    );

    function automatic string req_of(int k);
        case (k)
            K_BYTE:  return "R6";
            K_TRIG:  return "R7";
            K_BTA:   return "R4";
            K_EXIT:  return "R9";
            K_WAKE:  return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [7:0] data, input string req);
        exp_t e;
        e.kind = kind; e.data = data; e.req = req;
        expq.push_back(e);
    endtask

    task automatic observe(input int kind, input logic [7:0] data);
        exp_t e;
        checks++;
        if (expq.size() == 0) begin
            fails++;
            $display("FAIL %s: actual unexpected event %0d data %h expected none",
                     req_of(kind), kind, data);
        end else begin
            e = expq.pop_front();
            if (e.kind != kind || e.data !== data) begin
                fails++;
                $display("FAIL %s: actual event %0d data %h expected event %0d data %h",
                         e.req, kind, data, e.kind, e.data);
            end
        end
    endtask

    // monitor: pops the scoreboard as events appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid)        observe(K_BYTE, rx_byte);
            if (trig_pulse)      observe(K_TRIG, 8'h00);
            if (bta_pulse)       observe(K_BTA, 8'h00);
            if (esc_exit_pulse)  observe(K_EXIT, 8'h00);
            if (ulps_exit_pulse) observe(K_WAKE, 8'h00);
            if (seq_err)         observe(K_SERR, 8'h00);
        end
    end

    task automatic line(input logic [1:0] st, input int n);
        {lp_p, lp_n} = st;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input int n);
        for (int i = 0; i < 8; i++) begin
            line(v[i] ? 2'b10 : 2'b01, n);
            line(2'b00, n);
        end
    endtask

    task automatic esc_entry(input int n);
        line(2'b10, n); line(2'b00, n); line(2'b01, n); line(2'b00, n);
    endtask

    task automatic esc_leave(input int n);
        expect_ev(K_EXIT, 8'h00, "R9");
        line(2'b10, n); line(2'b11, H);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (H) @(negedge clk);
        // R1 reset state
        check("R1", {hs_req, esc_mode, ulps_mode, cmd_err, rx_valid, seq_err}, 8'h00);

        // R2 high-speed request
        line(2'b01, H); line(2'b00, H);
        check("R2", hs_req, 1'b1);
        line(2'b10, H); line(2'b00, H);
        check("R2", hs_req, 1'b1);
        line(2'b11, H);
        check("R2", hs_req, 1'b0);

        // R3 R5 R6 data escape
        esc_entry(H);
        check("R3", esc_mode, 1'b1);
        send_byte(C_LPDT, H);
        expect_ev(K_BYTE, 8'hA5, "R6");
        send_byte(8'hA5, H);
        expect_ev(K_BYTE, 8'h3C, "R5");
        send_byte(8'h3C, H);
        line(2'b01, H); line(2'b00, H);   // partial byte discarded at exit (R9)
        esc_leave(H);
        check("R9", esc_mode, 1'b0);

        // R6 one clock per line state: byte completion meets next Mark
        esc_entry(1);
        send_byte(C_LPDT, 1);
        expect_ev(K_BYTE, 8'h81, "R6");
        expect_ev(K_BYTE, 8'h7E, "R6");
        expect_ev(K_BYTE, 8'hFF, "R6");
        send_byte(8'h81, 1);
        send_byte(8'h7E, 1);
        send_byte(8'hFF, 1);
        esc_leave(1);

        // R7 trigger
        esc_entry(H);
        expect_ev(K_TRIG, 8'h00, "R7");
        send_byte(C_TRIG, H);
        send_byte(8'h55, H);
        esc_leave(H);

        // R8 unknown command
        esc_entry(H);
        send_byte(8'hC3, H);
        repeat (2) @(negedge clk);
        check("R8", cmd_err, 1'b1);
        send_byte(8'h99, H);
        esc_leave(H);
        check("R8", cmd_err, 1'b0);

        // R4 turnaround
        expect_ev(K_BTA, 8'h00, "R4");
        line(2'b10, H); line(2'b00, H); line(2'b10, H); line(2'b00, H);
        check("R4", {hs_req, esc_mode, ulps_mode}, 8'h00);
        line(2'b11, H);

        // R10 R11 ultra-low power
        esc_entry(H);
        send_byte(C_ULPS, H);
        repeat (2) @(negedge clk);
        check("R10", {esc_mode, ulps_mode}, 8'h01);
        line(2'b10, WAKE - 1); line(2'b11, H);
        check("R11", ulps_mode, 1'b1);
        line(2'b00, H);
        expect_ev(K_WAKE, 8'h00, "R11");
        line(2'b10, WAKE); line(2'b11, H);
        check("R11", ulps_mode, 1'b0);

        // R12 entry deviation, then nothing decoded until Stop
        expect_ev(K_SERR, 8'h00, "R12");
        line(2'b00, H);
        line(2'b01, H); line(2'b00, H);
        check("R12", hs_req, 1'b0);
        line(2'b11, H);

        // R12 two Marks without Space
        esc_entry(H);
        send_byte(C_LPDT, H);
        expect_ev(K_SERR, 8'h00, "R12");
        line(2'b01, H); line(2'b10, H);
        check("R12", esc_mode, 1'b0);
        line(2'b11, H);

        // R12 Stop in escape without Mark-1
        esc_entry(H);
        expect_ev(K_SERR, 8'h00, "R12");
        line(2'b01, H); line(2'b11, H);
        check("R12", esc_mode, 1'b0);

        // recovery after error
        line(2'b01, H); line(2'b00, H);
        check("R2", hs_req, 1'b1);
        line(2'b11, H);

        repeat (4) @(negedge clk);
        check("R6", 8'(expq.size()), 8'h00);
        summary();
    end

endmodule